// File: doc/BRIEF.md
# Hall sensor rotation direction detector

This block reports which way a three-phase brushless motor is turning, using only its three Hall sensor lines. The Hall lines are asynchronous to the chip, so the block samples them with a free-running system clock through a two-flop synchroniser on each line. A registered copy of the synchronised code, one cycle old, is kept beside it. Any difference between the two is taken as an update event and used as a clock enable. No register is ever clocked from a Hall line or from a signal derived from one.

The three lines form a code with the first Hall sensor as the most significant bit. Six codes are valid sectors. On each update event the new sector is compared with the sector tracked before it. A single step forward drives the direction output low and a single step backward drives it high. The block also presents a sector index for observation and a one-cycle pulse for each accepted sector change.

Top module: `hall_direction_detector`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, `sector_o` is 000, `dir_o` is 0 and `step_o` is 0. Reset is synchronous and active high.
- R2: A change on the Hall inputs, set up before a rising clock edge, reaches `sector_o`, `dir_o` and `step_o` on the third rising edge counted from that edge. The outputs do not change on the first two edges.
- R3: A one-step forward move drives `dir_o` to 0. The forward sequence of codes {hall1,hall2,hall3} is 100, 101, 001, 011, 010, 110, and it wraps from 110 back to 100.
- R4: A one-step backward move through that sequence (for example 101 to 100, or 100 to 110) drives `dir_o` to 1.
- R5: A move to a valid sector that is neither the forward nor the backward neighbour (a skipped sector) leaves `dir_o` unchanged. `sector_o` still takes the new sector.
- R6: `sector_o` gives the index of the tracked sector as 000 through 101, in the forward order listed in R3. It never shows 110. The value 111 is reserved for an invalid tracker state.
- R7: An invalid code, 000 or 111, sets `sector_o` to 000. It produces no `step_o` pulse and leaves `dir_o` unchanged.
- R8: The first valid sector seen after reset or after an invalid code is stored in `sector_o` without changing `dir_o`.
- R9: `step_o` is high for exactly one cycle, in the cycle `sector_o` takes a newly entered valid sector. It stays low while the Hall inputs are steady. `dir_o` changes only in a cycle in which `step_o` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running sampling clock |
| rst | input | 1 | Synchronous active-high reset |
| hall1 | input | 1 | First Hall sensor line, code MSB, asynchronous |
| hall2 | input | 1 | Second Hall sensor line, asynchronous |
| hall3 | input | 1 | Third Hall sensor line, code LSB, asynchronous |
| dir_o | output | 1 | Direction: 0 after a forward step, 1 after a backward step |
| sector_o | output | 3 | Index of the tracked sector, 000 to 101 (111 reserved for invalid) |
| step_o | output | 1 | One-cycle pulse on each accepted sector change |

## Verification
A wrong previous-sector register shows as a wrong `dir_o` on the very next step. It can also appear as a direction change on a step that should have been a skip. Both surface three cycles after the Hall change that exposes them. A stuck or missing delayed copy shows as extra or missing `step_o` pulses, or as an index that lags the inputs. A wrong first-sector flag shows only on the first step after reset or after an invalid code. For this reason every ordered pair of sectors is driven, and the invalid codes are placed between valid ones.

// File: rtl/hall_dir_pkg.sv
package hall_dir_pkg;
  localparam int CODE_W  = 3;
  localparam int NUM_SEC = 6;
  localparam int IDX_W   = 3;

  typedef logic [CODE_W-1:0] code_t;
  typedef logic [IDX_W-1:0]  idx_t;

  localparam idx_t IDX_BAD = 3'b111;

  function automatic logic code_valid(code_t c);
    return (c != 3'b000) && (c != 3'b111);
  endfunction

  function automatic idx_t code_to_idx(code_t c);
    idx_t r;
    case (c)
      3'b100:  r = 3'd0;
      3'b101:  r = 3'd1;
      3'b001:  r = 3'd2;
      3'b011:  r = 3'd3;
      3'b010:  r = 3'd4;
      3'b110:  r = 3'd5;
      default: r = 3'd0;
    endcase
    return r;
  endfunction

  function automatic idx_t idx_fwd(idx_t i);
    return (i == idx_t'(NUM_SEC - 1)) ? idx_t'(0) : idx_t'(i + 1);
  endfunction

  function automatic idx_t idx_bwd(idx_t i);
    return (i == idx_t'(0)) ? idx_t'(NUM_SEC - 1) : idx_t'(i - 1);
  endfunction
endpackage

// File: rtl/hall_sync.sv
module hall_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  logic [WIDTH-1:0] pipe [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) pipe[0] <= '0;
          else     pipe[0] <= async_i;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) pipe[s] <= '0;
          else     pipe[s] <= pipe[s-1];
        end
      end
    end
  endgenerate

  assign sync_o = pipe[STAGES-1];
endmodule

// File: rtl/sector_tracker.sv
module sector_tracker
  import hall_dir_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  code_t code_i,
  output idx_t  idx_o,
  output logic  dir_o,
  output logic  step_o
);
  code_t code_d;
  idx_t  idx_q;
  logic  have_q, dir_q, step_q;

  // named internal events
  logic chg_ev, valid_new, fwd_ev, bwd_ev, skip_ev;
  idx_t new_idx;

  assign chg_ev    = (code_i != code_d);
  assign valid_new = code_valid(code_i);
  assign new_idx   = code_to_idx(code_i);
  assign fwd_ev    = chg_ev && valid_new && have_q && (new_idx == idx_fwd(idx_q));
  assign bwd_ev    = chg_ev && valid_new && have_q && (new_idx == idx_bwd(idx_q));
  assign skip_ev   = chg_ev && valid_new && have_q && !fwd_ev && !bwd_ev;

  always_ff @(posedge clk) begin
    if (rst) begin
      code_d <= '0;
      idx_q  <= '0;
      have_q <= 1'b0;
      dir_q  <= 1'b0;
      step_q <= 1'b0;
    end else begin
      code_d <= code_i;
      step_q <= 1'b0;
      if (chg_ev) begin
        if (valid_new) begin
          idx_q  <= new_idx;
          have_q <= 1'b1;
          step_q <= 1'b1;
          if (fwd_ev)      dir_q <= 1'b0;
          else if (bwd_ev) dir_q <= 1'b1;
        end else begin
          idx_q  <= '0;
          have_q <= 1'b0;
        end
      end
    end
  end

  assign idx_o  = (idx_q < idx_t'(NUM_SEC)) ? idx_q : IDX_BAD;
  assign dir_o  = dir_q;
  assign step_o = step_q;

  a_r3_forward_clears_dir: assert property (@(posedge clk) disable iff (rst)
    fwd_ev |=> (dir_q == 1'b0));
  a_r4_backward_sets_dir: assert property (@(posedge clk) disable iff (rst)
    bwd_ev |=> (dir_q == 1'b1));
  a_r5_skip_holds_dir: assert property (@(posedge clk) disable iff (rst)
    skip_ev |=> ($stable(dir_q) && step_q));
  a_r7_invalid_to_first: assert property (@(posedge clk) disable iff (rst)
    (chg_ev && !valid_new) |=> (idx_q == 3'd0 && !step_q && $stable(dir_q) && !have_q));
  a_r8_first_no_dir: assert property (@(posedge clk) disable iff (rst)
    (chg_ev && valid_new && !have_q) |=> $stable(dir_q));
  a_r9_dir_moves_with_step: assert property (@(posedge clk) disable iff (rst)
    !$stable(dir_q) |-> step_q);
  a_r9_quiet_no_step: assert property (@(posedge clk) disable iff (rst)
    !chg_ev |=> !step_q);
endmodule

// File: rtl/hall_direction_detector.sv
module hall_direction_detector
  import hall_dir_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       hall1,
  input  logic       hall2,
  input  logic       hall3,
  output logic       dir_o,
  output logic [2:0] sector_o,
  output logic       step_o
);
  code_t hall_raw, hall_s;

  assign hall_raw = {hall1, hall2, hall3};

  hall_sync #(.WIDTH(CODE_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .async_i(hall_raw), .sync_o(hall_s)
  );

  sector_tracker u_track (
    .clk(clk), .rst(rst), .code_i(hall_s),
    .idx_o(sector_o), .dir_o(dir_o), .step_o(step_o)
  );

  a_r6_index_range: assert property (@(posedge clk) disable iff (rst)
    (sector_o < 3'd6) || (sector_o == 3'b111));
  a_r6_index_never_six: assert property (@(posedge clk) disable iff (rst)
    sector_o != 3'b110);
  a_r9_step_valid_index: assert property (@(posedge clk) disable iff (rst)
    step_o |-> (sector_o < 3'd6));
endmodule

// File: tb/hall_direction_detector_bench.sv
module hall_direction_detector_bench;
  logic clk = 1'b0, rst = 1'b1;
  logic h1 = 1'b0, h2 = 1'b0, h3 = 1'b0;
  logic dir_o, step_o;
  logic [2:0] sector_o;
  int checks = 0, fails = 0, pulses = 0;
  bit done = 0;

  always #2 clk = ~clk;

  hall_direction_detector u_hall_direction_detector (
    .clk(clk), .rst(rst), .hall1(h1), .hall2(h2), .hall3(h3),
    .dir_o(dir_o), .sector_o(sector_o), .step_o(step_o)
  );

  always @(negedge clk) if (!rst && step_o === 1'b1) pulses++;

  logic [2:0] seq [6] = '{3'b100, 3'b101, 3'b001, 3'b011, 3'b010, 3'b110};

  // bench model state
  int  m_idx = 0;
  bit  m_have = 0;
  bit  m_dir = 0;
  logic [2:0] m_code = 3'b000;

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // drive a code at a falling edge, let it settle, check outputs
  task automatic drive(logic [2:0] c, string req);
    int p0;
    int d;
    bit ok_code;
    @(negedge clk);
    p0 = pulses;
    {h1, h2, h3} = c;
    repeat (5) @(negedge clk);
    ok_code = (c != 3'b000) && (c != 3'b111);
    if (c != m_code) begin
      if (ok_code) begin
        int n = 0;
        for (int k = 0; k < 6; k++) if (seq[k] == c) n = k;
        if (m_have) begin
          d = (n - m_idx + 6) % 6;
          if (d == 1) m_dir = 0;
          else if (d == 5) m_dir = 1;
        end
        m_idx = n; m_have = 1;
        chk({req, " R9 one pulse"}, pulses - p0, 1);
      end else begin
        m_idx = 0; m_have = 0;
        chk({req, " R7 no pulse"}, pulses - p0, 0);
      end
    end else begin
      chk({req, " R9 steady no pulse"}, pulses - p0, 0);
    end
    m_code = c;
    chk({req, " R6 sector"}, int'(sector_o), m_idx);
    chk({req, " dir"}, int'(dir_o), int'(m_dir));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset sector", int'(sector_o), 0);
    chk("R1 reset dir", int'(dir_o), 0);
    chk("R1 reset step", int'(step_o), 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 after release sector", int'(sector_o), 0);
    chk("R1 after release step", int'(step_o), 0);

    // R2: latency, first valid sector (R8)
    @(negedge clk);
    {h1, h2, h3} = 3'b011;
    @(negedge clk); chk("R2 edge1 step", int'(step_o), 0);
    @(negedge clk); chk("R2 edge2 step", int'(step_o), 0);
    chk("R2 edge2 sector", int'(sector_o), 0);
    @(negedge clk); chk("R2 edge3 step", int'(step_o), 1);
    chk("R2 edge3 sector", int'(sector_o), 3);
    chk("R8 first sector keeps dir", int'(dir_o), 0);
    @(negedge clk); chk("R9 pulse one cycle", int'(step_o), 0);
    m_code = 3'b011; m_idx = 3; m_have = 1; m_dir = 0;

    // R4 then R3 with wrap
    drive(3'b001, "R4 back 3->2");
    drive(3'b101, "R4 back 2->1");
    drive(3'b100, "R4 back 1->0");
    drive(3'b110, "R4 back wrap 0->5");
    drive(3'b100, "R3 fwd wrap 5->0");
    drive(3'b100, "R9 steady");

    // sweep every ordered pair of sectors
    for (int a = 0; a < 6; a++)
      for (int b = 0; b < 6; b++) begin
        drive(seq[a], "R3/R4/R5 sweep from");
        drive(seq[b], "R3/R4/R5 sweep to");
      end

    // R5 skipped sector holds dir
    drive(seq[2], "R5 setup");
    drive(seq[1], "R4 setup dir=1");
    drive(seq[4], "R5 skip holds dir");
    chk("R5 dir held at 1", int'(dir_o), 1);

    // R7/R8 invalid codes then first valid sector
    drive(3'b000, "R7 invalid 000");
    chk("R7 sector to 0", int'(sector_o), 0);
    chk("R7 dir held", int'(dir_o), 1);
    drive(3'b111, "R7 invalid 111");
    drive(seq[5], "R8 first after invalid");
    chk("R8 dir unchanged", int'(dir_o), 1);
    drive(seq[0], "R3 fwd after first");
    chk("R3 dir low", int'(dir_o), 0);
    drive(seq[5], "R4 back");
    drive(3'b111, "R7 invalid 111 again");
    drive(seq[0], "R8 first 100 after invalid");
    chk("R8 dir still 1", int'(dir_o), 1);

    // R1 reset mid-run
    @(negedge clk); rst = 1'b1;
    @(negedge clk);
    chk("R1 mid reset sector", int'(sector_o), 0);
    chk("R1 mid reset dir", int'(dir_o), 0);
    {h1, h2, h3} = 3'b000;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    m_code = 3'b000; m_idx = 0; m_have = 0; m_dir = 0;
    drive(seq[3], "R8 first after reset");
    drive(seq[2], "R4 back after reset");
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
      end
    join_any
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule